// File: doc/BRIEF.md
# PHY Register Programming and Calibration Sequencer

This block brings a serial-link PHY from reset to a calibrated state without software. After a one-cycle start pulse it pushes a table of register writes into the PHY through a simple request/acknowledge register port. It then forces a recalibration by dropping and raising a calibration-force bit, with a one-millisecond pause between the two writes. The table contents, the mode enables and a free-running millisecond tick all come in as inputs.

Two optional stages follow the toggle. The first puts the PHY in a debug mode and polls a status register until the calibration-done flag appears. A fail flag records a timeout, and the debug registers are put back afterwards either way. The second reads the receiver offset code. If that code has saturated at either end, the block widens a 2-bit offset-range field and runs the whole calibration again. This loop ends once the field reaches its top value or the code is no longer saturated. When the last step is complete the block pulses `done_o`.

Top module: `phy_init_seq`

## Requirements
- R1: Table entry i occupies bits [24*i+23 : 24*i] of `tbl_i`, with the address in the upper 8 bits and the data in the lower 16. Entries whose 24 bits are all zero are skipped. Every other entry is written in ascending index order. When `use_dflt_i` is set, no table entry is written.
- R2: If `en_tgl_i` or `en_once_i` is set, the calibration toggle runs. It writes register 0x09 with bit 9 cleared, waits for TICKS_PER_MS pulses of `ms_tick_i`, then writes 0x09 with bit 9 set. If both enables are clear, register 0x09 is never touched after the table.
- R3: The toggle base value is the data of table entry 9 when that entry is non-empty. Otherwise the block reads register 0x09 once per run and reuses that value for every later toggle in the same run.
- R4: When `en_once_i` is set, after each toggle the block reads 0x0D and then 0x10. It then writes 0x0D with bit 6 set, and writes 0x10 with bits 9:3 replaced so that (value & 0x3F8) equals 0x3C0.
- R5: In the same mode, register 0x30 is read until bit 15 is set, at most POLL_TRIES (11) reads, with one millisecond delay between consecutive reads. If no read shows bit 15, `fail_o` is set.
- R6: After polling ends, 0x0D and then 0x10 are written back with the values read in R4, whether the poll passed or failed.
- R7: When `en_ofs_i` is set, the block reads 0x1F and then 0x0B. An update is needed only if bits 4:1 of the 0x1F value are 4'b0000 or 4'b1111.
- R8: If an update is needed and bits 3:2 of the 0x0B value are not 2'b11, the block writes 0x0B back with that field incremented by one and all other bits unchanged, then re-enters R2. Otherwise it finishes.
- R9: `reg_req_o` stays high, with address, write-enable and write data held stable, until `reg_ack_i` is seen. Only one transaction is outstanding at a time.
- R10: `done_o` is high for exactly one cycle per run, after the last transaction. `fail_o` keeps its value after `done_o` and is cleared when the next run starts.
- R11: A start pulse while a run is in progress is ignored. No port activity occurs while idle.
- R12: After reset, `reg_req_o`, `done_o` and `fail_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle run request |
| use_dflt_i | input | 1 | Skip the table write stage |
| en_tgl_i | input | 1 | Enable calibration toggle |
| en_once_i | input | 1 | Enable toggle with debug-mode poll of the done flag |
| en_ofs_i | input | 1 | Enable receiver offset check and range widening |
| ms_tick_i | input | 1 | One-cycle pulse per millisecond |
| tbl_i | input | 24*N_ENT | Packed table of {addr[7:0], data[15:0]} entries |
| reg_req_o | output | 1 | Register port request |
| reg_we_o | output | 1 | 1 = write, 0 = read |
| reg_addr_o | output | 8 | Register address |
| reg_wdata_o | output | 16 | Write data |
| reg_ack_i | input | 1 | Register port acknowledge, one cycle |
| reg_rdata_i | input | 16 | Read data, valid with acknowledge |
| done_o | output | 1 | One-cycle completion pulse |
| fail_o | output | 1 | Calibration-done flag never seen |

## Verification
Two events can land in the same cycle, and the bench drives both deliberately. The first is a start pulse that arrives while the sequencer is busy in its debug-poll stage. It is judged by comparing the whole transaction stream against an independently computed expected list, so a restart would show up as an extra or misordered access. The second is a free-running millisecond tick that can fall on the same cycle a delay is armed. The bench runs its tick phase unaligned to the transactions and checks that at least one tick separates the two toggle writes. Port latency changes between runs, which moves where these collisions fall.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int EW = AW + DW;

  localparam logic [AW-1:0] A_CAL     = 8'h09;
  localparam logic [AW-1:0] A_RNG     = 8'h0B;
  localparam logic [AW-1:0] A_DBGEN   = 8'h0D;
  localparam logic [AW-1:0] A_DBGMD   = 8'h10;
  localparam logic [AW-1:0] A_CODE    = 8'h1F;
  localparam logic [AW-1:0] A_STAT    = 8'h30;

  localparam logic [DW-1:0] M_CAL     = 16'h0200;
  localparam logic [DW-1:0] M_DBGEN   = 16'h0040;
  localparam logic [DW-1:0] M_DBGMD   = 16'h03F8;
  localparam logic [DW-1:0] V_DBGMD   = 16'h03C0;
  localparam int            B_STAT    = 15;
  localparam int            CODE_LSB  = 1;
  localparam int            CODE_W    = 4;
  localparam int            RNG_LSB   = 2;
  localparam int            RNG_W     = 2;

  typedef enum logic [4:0] {
    S_IDLE, S_TBL, S_TGL_ENT, S_BASE_RD, S_TG_LO, S_TG_WAIT, S_TG_HI,
    S_POST, S_SV0D, S_SV10, S_DBG0D, S_DBG10, S_POLL, S_POLL_WAIT,
    S_RS0D, S_RS10, S_OFS_CODE, S_OFS_RNG, S_OFS_WR, S_DONE
  } seq_st_t;
endpackage

// File: rtl/phy_seq_delay.sv
module phy_seq_delay #(
  parameter int TICKS = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic go_i,
  input  logic tick_i,
  output logic fin_o
);
  localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;

  logic          act_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= 1'b0;
      cnt_q <= '0;
      fin_o <= 1'b0;
    end else begin
      fin_o <= 1'b0;
      if (go_i) begin
        act_q <= 1'b1;
        cnt_q <= '0;
      end else if (act_q && tick_i) begin
        if (cnt_q == CW'(TICKS - 1)) begin
          act_q <= 1'b0;
          fin_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  AST_FIN_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    fin_o |-> $past(tick_i)); // R2
endmodule

// File: rtl/phy_seq_xact.sv
module phy_seq_xact
  import phy_seq_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          go_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          ack_i,
  input  logic [DW-1:0] rdata_i,
  output logic          req_o,
  output logic          we_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  output logic          done_o,
  output logic [DW-1:0] rdata_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      req_o   <= 1'b0;
      we_o    <= 1'b0;
      addr_o  <= '0;
      wdata_o <= '0;
      done_o  <= 1'b0;
      rdata_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (go_i && !req_o) begin
        req_o   <= 1'b1;
        we_o    <= we_i;
        addr_o  <= addr_i;
        wdata_o <= wdata_i;
      end else if (req_o && ack_i) begin
        req_o   <= 1'b0;
        done_o  <= 1'b1;
        rdata_o <= rdata_i;
      end
    end
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (req_o && !ack_i) |=> (req_o && $stable(addr_o) && $stable(we_o) && $stable(wdata_o))); // R9
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
    go_i |-> !req_o); // R9
endmodule

// File: rtl/phy_init_seq.sv
module phy_init_seq
  import phy_seq_pkg::*;
#(
  parameter int N_ENT        = 48,
  parameter int TICKS_PER_MS = 1,
  parameter int POLL_TRIES   = 11,
  parameter int TGL_IDX      = 9
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  input  logic                use_dflt_i,
  input  logic                en_tgl_i,
  input  logic                en_once_i,
  input  logic                en_ofs_i,
  input  logic                ms_tick_i,
  input  logic [N_ENT*24-1:0] tbl_i,
  output logic                reg_req_o,
  output logic                reg_we_o,
  output logic [7:0]          reg_addr_o,
  output logic [15:0]         reg_wdata_o,
  input  logic                reg_ack_i,
  input  logic [15:0]         reg_rdata_i,
  output logic                done_o,
  output logic                fail_o
);
  localparam int IW = (N_ENT > 1) ? $clog2(N_ENT) : 1;
  localparam int PW = $clog2(POLL_TRIES + 1);

  seq_st_t       st_q;
  logic [IW-1:0] idx_q;
  logic [PW-1:0] polls_q;
  logic          pend_q, base_vld_q, need_q;
  logic [DW-1:0] base_q, sv0d_q, sv10_q, rng_q, rng_nxt;

  logic          x_act, x_go, x_we, x_done, d_act, d_go, d_fin;
  logic [AW-1:0] x_addr;
  logic [DW-1:0] x_wdata, x_rdata;
  logic [EW-1:0] ent, ent_tgl;

  assign ent     = tbl_i[int'(idx_q)*EW +: EW];
  assign ent_tgl = tbl_i[TGL_IDX*EW +: EW];

  always_comb begin
    rng_nxt = rng_q;
    rng_nxt[RNG_LSB +: RNG_W] = rng_q[RNG_LSB +: RNG_W] + 1'b1;
  end

  always_comb begin
    x_act = 1'b0; x_we = 1'b0; x_addr = '0; x_wdata = '0; d_act = 1'b0;
    case (st_q)
      S_TBL:       begin x_act = |ent; x_we = 1'b1; x_addr = ent[EW-1 -: AW]; x_wdata = ent[DW-1:0]; end
      S_BASE_RD:   begin x_act = 1'b1; x_addr = A_CAL; end
      S_TG_LO:     begin x_act = 1'b1; x_we = 1'b1; x_addr = A_CAL; x_wdata = base_q & ~M_CAL; end
      S_TG_WAIT:   d_act = 1'b1;
      S_TG_HI:     begin x_act = 1'b1; x_we = 1'b1; x_addr = A_CAL; x_wdata = base_q | M_CAL; end
      S_SV0D:      begin x_act = 1'b1; x_addr = A_DBGEN; end
      S_SV10:      begin x_act = 1'b1; x_addr = A_DBGMD; end
      S_DBG0D:     begin x_act = 1'b1; x_we = 1'b1; x_addr = A_DBGEN; x_wdata = sv0d_q | M_DBGEN; end
      S_DBG10:     begin x_act = 1'b1; x_we = 1'b1; x_addr = A_DBGMD; x_wdata = (sv10_q & ~M_DBGMD) | V_DBGMD; end
      S_POLL:      begin x_act = 1'b1; x_addr = A_STAT; end
      S_POLL_WAIT: d_act = 1'b1;
      S_RS0D:      begin x_act = 1'b1; x_we = 1'b1; x_addr = A_DBGEN; x_wdata = sv0d_q; end
      S_RS10:      begin x_act = 1'b1; x_we = 1'b1; x_addr = A_DBGMD; x_wdata = sv10_q; end
      S_OFS_CODE:  begin x_act = 1'b1; x_addr = A_CODE; end
      S_OFS_RNG:   begin x_act = 1'b1; x_addr = A_RNG; end
      S_OFS_WR:    begin x_act = 1'b1; x_we = 1'b1; x_addr = A_RNG; x_wdata = rng_nxt; end
      default: ;
    endcase
    x_go = x_act && !pend_q;
    d_go = d_act && !pend_q;
  end

  phy_seq_xact u_xact (
    .clk(clk), .rst(rst), .go_i(x_go), .we_i(x_we), .addr_i(x_addr), .wdata_i(x_wdata),
    .ack_i(reg_ack_i), .rdata_i(reg_rdata_i), .req_o(reg_req_o), .we_o(reg_we_o),
    .addr_o(reg_addr_o), .wdata_o(reg_wdata_o), .done_o(x_done), .rdata_o(x_rdata)
  );

  phy_seq_delay #(.TICKS(TICKS_PER_MS)) u_dly (
    .clk(clk), .rst(rst), .go_i(d_go), .tick_i(ms_tick_i), .fin_o(d_fin)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= S_IDLE; idx_q <= '0; polls_q <= '0; pend_q <= 1'b0;
      base_vld_q <= 1'b0; need_q <= 1'b0; base_q <= '0; sv0d_q <= '0;
      sv10_q <= '0; rng_q <= '0; done_o <= 1'b0; fail_o <= 1'b0;
    end else begin
      done_o <= (st_q == S_DONE);
      if (x_go || d_go)        pend_q <= 1'b1;
      else if (x_done || d_fin) pend_q <= 1'b0;
      case (st_q)
        S_IDLE: if (start_i) begin
          fail_o     <= 1'b0;
          idx_q      <= '0;
          base_vld_q <= |ent_tgl;
          base_q     <= ent_tgl[DW-1:0];
          st_q       <= use_dflt_i ? S_TGL_ENT : S_TBL;
        end
        S_TBL: if (!(|ent) || x_done) begin
          if (idx_q == IW'(N_ENT - 1)) st_q <= S_TGL_ENT;
          else idx_q <= idx_q + 1'b1;
        end
        S_TGL_ENT:
          if (!(en_tgl_i || en_once_i)) st_q <= S_POST;
          else st_q <= base_vld_q ? S_TG_LO : S_BASE_RD;
        S_BASE_RD: if (x_done) begin
          base_q <= x_rdata; base_vld_q <= 1'b1; st_q <= S_TG_LO;
        end
        S_TG_LO:   if (x_done) st_q <= S_TG_WAIT;
        S_TG_WAIT: if (d_fin)  st_q <= S_TG_HI;
        S_TG_HI:   if (x_done) st_q <= S_POST;
        S_POST:
          if (en_once_i)     st_q <= S_SV0D;
          else if (en_ofs_i) st_q <= S_OFS_CODE;
          else               st_q <= S_DONE;
        S_SV0D:  if (x_done) begin sv0d_q <= x_rdata; st_q <= S_SV10; end
        S_SV10:  if (x_done) begin sv10_q <= x_rdata; st_q <= S_DBG0D; end
        S_DBG0D: if (x_done) st_q <= S_DBG10;
        S_DBG10: if (x_done) begin polls_q <= '0; st_q <= S_POLL; end
        S_POLL: if (x_done) begin
          if (x_rdata[B_STAT]) st_q <= S_RS0D;
          else if (polls_q == PW'(POLL_TRIES - 1)) begin fail_o <= 1'b1; st_q <= S_RS0D; end
          else begin polls_q <= polls_q + 1'b1; st_q <= S_POLL_WAIT; end
        end
        S_POLL_WAIT: if (d_fin) st_q <= S_POLL;
        S_RS0D: if (x_done) st_q <= S_RS10;
        S_RS10: if (x_done) st_q <= en_ofs_i ? S_OFS_CODE : S_DONE;
        S_OFS_CODE: if (x_done)
          need_q <= (x_rdata[CODE_LSB +: CODE_W] == '0) || (&x_rdata[CODE_LSB +: CODE_W]);
        S_OFS_RNG: if (x_done) begin
          rng_q <= x_rdata;
          st_q  <= (need_q && !(&x_rdata[RNG_LSB +: RNG_W])) ? S_OFS_WR : S_DONE;
        end
        S_OFS_WR: if (x_done) st_q <= S_TGL_ENT;
        S_DONE:   st_q <= S_IDLE;
        default:  st_q <= S_IDLE;
      endcase
      if (st_q == S_OFS_CODE && x_done) st_q <= S_OFS_RNG;
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R10
  AST_FAIL_NEEDS_POLL: assert property (@(posedge clk) disable iff (rst)
    $rose(fail_o) |-> en_once_i); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_IDLE && $past(st_q) == S_IDLE) |-> !reg_req_o); // R11
  AST_RANGE_GROWS: assert property (@(posedge clk) disable iff (rst)
    (reg_req_o && reg_we_o && st_q == S_OFS_WR) |-> (reg_wdata_o[RNG_LSB +: RNG_W] != 2'b00)); // R8
endmodule

// File: tb/phy_init_seq_tb_top.sv
module phy_init_seq_tb_top;
  localparam int NE = 48;
  localparam int TICK_PER = 16;

  typedef struct {
    bit          we;
    logic [7:0]  a;
    logic [15:0] d;
    string       tag;
  } xp_t;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic use_dflt = 1'b0, en_tgl = 1'b0, en_once = 1'b0, en_ofs = 1'b0, ms_tick = 1'b0;
  logic [NE*24-1:0] tbl = '0;
  logic        reg_req, reg_we, reg_ack = 1'b0, done, fail;
  logic [7:0]  reg_addr;
  logic [15:0] reg_wdata, reg_rdata = '0;

  int checks = 0, errors = 0;
  int lat = 0, wcnt = 0, cal_after = 0, phy_polls = 0, gpolls = 0;
  int tick_ctr = 0, ticks_total = 0, lo_ticks = 0;
  bit running = 0, done_seen = 0, prev_done = 0, efail = 0, holding = 0;
  logic [7:0]  hold_a;
  logic [15:0] hold_d;
  bit          hold_we;
  logic [15:0] phy_mem [64];
  logic [15:0] gm [64];
  xp_t exp_q[$];

  always #10 clk = ~clk;

  phy_init_seq dut_i (
    .clk(clk), .rst(rst), .start_i(start), .use_dflt_i(use_dflt), .en_tgl_i(en_tgl),
    .en_once_i(en_once), .en_ofs_i(en_ofs), .ms_tick_i(ms_tick), .tbl_i(tbl),
    .reg_req_o(reg_req), .reg_we_o(reg_we), .reg_addr_o(reg_addr), .reg_wdata_o(reg_wdata),
    .reg_ack_i(reg_ack), .reg_rdata_i(reg_rdata), .done_o(done), .fail_o(fail)
  );

  task automatic chk(bit ok, string tag, string what, int got, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, got, exp);
    end
  endtask

  // expected-stream generator, built from the requirements
  task automatic gwr(logic [7:0] a, logic [15:0] d, string tag);
    xp_t e; e.we = 1; e.a = a; e.d = d; e.tag = tag;
    exp_q.push_back(e); gm[a[5:0]] = d;
  endtask
  task automatic grd(logic [7:0] a, string tag, output logic [15:0] v);
    xp_t e; e.we = 0; e.a = a; e.d = '0; e.tag = tag;
    exp_q.push_back(e);
    v = gm[a[5:0]];
    if (a == 8'h30) begin gpolls++; if (gpolls > cal_after) v = v | 16'h8000; end
  endtask

  task automatic gen();
    logic [15:0] base, v0d, v10, c, r, v;
    bit have_base, again, ok, need;
    exp_q.delete(); gpolls = 0; efail = 0;
    for (int i = 0; i < 64; i++) gm[i] = phy_mem[i];
    if (!use_dflt)
      for (int i = 0; i < NE; i++)
        if (tbl[i*24 +: 24] != 0) gwr(tbl[i*24+16 +: 8], tbl[i*24 +: 16], "R1");
    have_base = (tbl[9*24 +: 24] != 0);
    base = tbl[9*24 +: 16];
    again = 1;
    while (again) begin
      if (en_tgl || en_once) begin
        if (!have_base) begin grd(8'h09, "R3", base); have_base = 1; end
        gwr(8'h09, base & ~16'h0200, "R2");
        gwr(8'h09, base | 16'h0200, "R2");
      end
      if (en_once) begin
        grd(8'h0D, "R4", v0d); grd(8'h10, "R4", v10);
        gwr(8'h0D, v0d | 16'h0040, "R4");
        gwr(8'h10, (v10 & ~16'h03F8) | 16'h03C0, "R4");
        ok = 0;
        for (int k = 0; k < 11; k++) begin
          grd(8'h30, "R5", v);
          if (v[15]) begin ok = 1; break; end
        end
        if (!ok) efail = 1;
        gwr(8'h0D, v0d, "R6"); gwr(8'h10, v10, "R6");
      end
      again = 0;
      if (en_ofs) begin
        grd(8'h1F, "R7", c); grd(8'h0B, "R7", r);
        need = (c[4:1] == 4'h0) || (c[4:1] == 4'hF);
        if (need && r[3:2] != 2'b11) begin
          r[3:2] = r[3:2] + 2'd1;
          gwr(8'h0B, r, "R8");
          again = 1;
        end
      end
    end
  endtask

  task automatic observe();
    xp_t e;
    logic [15:0] v;
    checks++;
    if (exp_q.size() == 0) begin
      errors++;
      $display("FAIL R11 unexpected access: actual addr 0x%0h we %0d expected none", reg_addr, reg_we);
      return;
    end
    e = exp_q.pop_front();
    chk(reg_we == e.we && reg_addr == e.a, e.tag, "access kind/addr",
        {reg_we, reg_addr}, {e.we, e.a});
    if (e.we) begin
      chk(reg_wdata == e.d, e.tag, "write data", reg_wdata, e.d);
      phy_mem[reg_addr[5:0]] = reg_wdata;
      if (e.tag == "R2" && reg_addr == 8'h09) begin
        if (!reg_wdata[9]) lo_ticks = ticks_total;
        else chk(ticks_total - lo_ticks >= 1, "R2", "ticks between toggle writes",
                 ticks_total - lo_ticks, 1);
      end
    end else begin
      v = phy_mem[reg_addr[5:0]];
      if (reg_addr == 8'h30) begin phy_polls++; if (phy_polls > cal_after) v = v | 16'h8000; end
      reg_rdata = v;
    end
  endtask

  // PHY port model, hold check and per-clock comparison
  always @(negedge clk) begin
    tick_ctr++;
    ms_tick = (tick_ctr % TICK_PER == 0);
    if (ms_tick) ticks_total++;
    if (rst) begin
      reg_ack = 0; wcnt = 0; holding = 0;
    end else begin
      if (holding && reg_req && !(reg_addr == hold_a && reg_we == hold_we && reg_wdata == hold_d))
        chk(0, "R9", "request not held", reg_addr, hold_a);
      if (reg_ack) begin
        reg_ack = 0;
      end else if (reg_req) begin
        if (!holding) begin holding = 1; hold_a = reg_addr; hold_we = reg_we; hold_d = reg_wdata; end
        if (wcnt < lat) wcnt++;
        else begin wcnt = 0; holding = 0; observe(); reg_ack = 1; end
      end
      if (!running && reg_req) chk(0, "R11", "port active while idle", 1, 0);
      if (done) begin
        chk(exp_q.size() == 0, "R10", "done with accesses left", exp_q.size(), 0);
        chk(!prev_done, "R10", "done longer than one cycle", 1, 0);
        done_seen = 1;
      end
      prev_done = done;
    end
  end

  task automatic init_mem(logic [15:0] code, logic [15:0] rng);
    for (int i = 0; i < 64; i++) phy_mem[i] = 16'(i * 16'h0313);
    phy_mem[6'h30] = 16'h0042;
    phy_mem[6'h1F] = code;
    phy_mem[6'h0B] = rng;
  endtask

  task automatic run(bit dflt, bit tg, bit once, bit ofs, int lat_v, int cal,
                     logic [15:0] code, logic [15:0] rng, bit poke);
    use_dflt = dflt; en_tgl = tg; en_once = once; en_ofs = ofs;
    lat = lat_v; cal_after = cal; phy_polls = 0;
    init_mem(code, rng);
    gen();
    running = 1; done_seen = 0;
    @(negedge clk); start = 1; @(negedge clk); start = 0;
    repeat (3) @(negedge clk);
    chk(fail == 1'b0, "R10", "fail cleared by start", fail, 0);
    if (poke) begin
      repeat (20) @(negedge clk);
      start = 1; @(negedge clk); start = 0;   // R11: ignored mid-run
    end
    while (!done_seen) @(negedge clk);
    chk(fail == efail, "R5", "fail flag at done", fail, efail);
    repeat (4) @(negedge clk);
    chk(fail == efail, "R10", "fail held after done", fail, efail);
    running = 0;
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk(reg_req == 0 && done == 0 && fail == 0, "R12", "reset outputs",
        {reg_req, done, fail}, 0);
    rst = 0;
    repeat (3) @(negedge clk);

    // R1: full table with holes, entry 0 has zero address but data
    for (int i = 0; i < NE; i++) tbl[i*24 +: 24] = {8'(i), 16'(16'hA000 + i)};
    tbl[5*24 +: 24] = '0; tbl[20*24 +: 24] = '0;
    tbl[9*24 +: 24] = {8'h09, 16'h1234};
    run(0, 1, 0, 0, 0, 0, 16'h0004, 16'h0000, 0);

    // R3: sparse table, entry 9 empty -> live read
    tbl = '0;
    tbl[3*24 +: 24]  = {8'h03, 16'h0055};
    tbl[40*24 +: 24] = {8'h28, 16'hF842};
    tbl[47*24 +: 24] = {8'h00, 16'h0001};
    run(0, 1, 0, 0, 2, 0, 16'h0004, 16'h0000, 0);

    // R4 R6 R11: defaults, once mode, poll passes on 4th read, start poked mid-run
    run(1, 0, 1, 0, 1, 3, 16'h0004, 16'h0000, 1);

    // R5: poll never passes
    run(1, 0, 1, 0, 0, 1000, 16'h0004, 16'h0000, 0);

    // R8: saturated low code, range climbs 0 -> 3 with re-toggles
    run(0, 1, 0, 1, 1, 0, 16'h0000, 16'h0000, 0);

    // R7: code not saturated -> no range write
    run(0, 1, 0, 1, 0, 0, 16'h000A, 16'h0004, 0);

    // R8: code all ones but range already at top -> no write
    run(1, 0, 1, 1, 3, 0, 16'h001E, 16'h000C, 0);

    // R2 R8: no toggle enables, one range step then stop
    run(1, 0, 0, 1, 1, 0, 16'h001F, 16'h0009, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule